// File: doc/BRIEF.md
# Four-Level Masked Interrupt Aggregator

This block collects level-sensitive interrupt requests from peripheral devices and groups them into four priority levels, numbered 3 to 6, with up to four devices in each level. For every level a register shows which devices are asking for service right now. A second register holds the devices that are allowed to interrupt. Each level drives one request line towards the processor's interrupt logic, and that line is high while at least one allowed device of the level is requesting.

Software reaches the eight registers over a simple synchronous bus: an address, a write strobe, eight bits of write data and eight bits of registered read data. An enable register is never overwritten as a whole. The top bit of the written byte picks between setting and clearing, and the low four bits name the devices that are affected. Two drivers can therefore each own their own device bits without a read-modify-write race. For example, writing 0x81, then 0x86, then 0x02 leaves devices 0 and 2 enabled. Level 3 carries the network controller on device 0. Level 4 carries two serial channels on devices 1 and 2 and the network DMA completion on device 3.

Top module: `irq_level_agg`

## Requirements
- R1: Reading a level's status register returns, in bits [3:0], that level's four request inputs as sampled at the clock edge that captures the read address, with bits [7:4] zero; the data appears on `busRdata` one cycle after the address.
- R2: Reading a level's enable register returns that level's current four enable bits in bits [3:0], with bits [7:4] zero, one cycle after the address.
- R3: A write to an enable register with data bit 7 equal to 1 sets every enable bit whose position is 1 in data bits [3:0] and leaves the other enable bits unchanged.
- R4: A write to an enable register with data bit 7 equal to 0 clears every enable bit whose position is 1 in data bits [3:0] and leaves the other enable bits unchanged; data bits [6:4] have no effect in either mode.
- R5: `irqLevel[i]` is high exactly when some device d of level index i has both its request and its enable bit set. It follows request changes in the same cycle and follows enable writes right after the writing clock edge.
- R6: Level index i (0 to 3) stands for level 3+i. Its status register is at byte offset 0x130 + 0x10*i and its enable register is at 0x134 + 0x10*i. Its device d drives `devReq[4*i+d]` and `irqLevel[i]`.
- R7: After reset all enable bits are 0, every `irqLevel` bit is 0 and `busRdata` is 0.
- R8: Reads from any offset that is not one of the eight registers return 0. Writes to such offsets, and writes to status registers, change no enable bit.
- R9: A write to one level's enable register leaves the enable bits of the other three levels unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W (12) | Register byte offset |
| busWr | input | 1 | Write strobe for the current address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the address of the previous cycle |
| devReq | input | 16 | Device request lines, level index i at bits [4i+3:4i] |
| irqLevel | output | 4 | Per-level interrupt request, index 0 is level 3 |

## Verification
Read data is due one cycle after the address. The bench therefore drives the address on a falling edge and samples `busRdata` on the next falling edge, after exactly one rising edge. Enable writes take effect on the rising edge that sees the strobe, so the enable readback and `irqLevel` are checked starting at the falling edge that follows. `irqLevel` is combinational from the requests, so after each change of `devReq` it is checked one nanosecond later, inside the same cycle. The sweep covers every enable mask against every request pattern on every level, and the bench keeps its own model of the enable bits to compute the expected values.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int LEVELS       = 4;
  localparam int DEVS         = 4;
  localparam int DATA_W       = 8;
  localparam int FIRST_LEVEL  = 3;
  localparam int REG_BASE     = 'h100;
  localparam int LEVEL_STRIDE = 'h10;
  localparam int ENABLE_GAP   = 4;
  localparam int SET_BIT      = 7;
  localparam int LVL_W        = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int REQ_W        = LEVELS * DEVS;

  // Strobes from the decode to the register datapath.
  typedef struct packed {
    logic [LEVELS-1:0] enWr;
    logic              setMode;
    logic [DEVS-1:0]   bitMask;
    logic              rdStatus;
    logic              rdEnable;
    logic [LVL_W-1:0]  rdLevel;
  } strobe_t;

  function automatic int statusOffset(input int idx);
    return REG_BASE + (FIRST_LEVEL + idx) * LEVEL_STRIDE;
  endfunction

  function automatic int enableOffset(input int idx);
    return statusOffset(idx) + ENABLE_GAP;
  endfunction

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           stb
);

  // Bits between the device mask and the mode bit carry no meaning.
  logic unusedWdataBits;
  assign unusedWdataBits = ^busWdata[SET_BIT-1:DEVS];

  always_comb begin
    stb          = '0;
    stb.setMode  = busWdata[SET_BIT];
    stb.bitMask  = busWdata[DEVS-1:0];
    for (int i = 0; i < LEVELS; i++) begin
      if (busAddr == ADDR_W'(statusOffset(i))) begin
        stb.rdStatus = 1'b1;
        stb.rdLevel  = LVL_W'(i);
      end
      if (busAddr == ADDR_W'(enableOffset(i))) begin
        stb.rdEnable = 1'b1;
        stb.rdLevel  = LVL_W'(i);
        stb.enWr[i]  = busWr;
      end
    end
  end

endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [REQ_W-1:0]  devReq,
  output logic [REQ_W-1:0]  enMask,
  output logic [LEVELS-1:0] irqLevel,
  output logic [DATA_W-1:0] busRdata
);

  logic [DEVS-1:0] rdNibble;

  for (genvar g = 0; g < LEVELS; g++) begin : gLevel
    logic [DEVS-1:0] enReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enReg <= '0;
      end else if (stb.enWr[g]) begin
        if (stb.setMode) enReg <= enReg | stb.bitMask;
        else             enReg <= enReg & ~stb.bitMask;
      end
    end

    assign enMask[g*DEVS +: DEVS] = enReg;
    assign irqLevel[g] = |(devReq[g*DEVS +: DEVS] & enReg);
  end

  always_comb begin
    rdNibble = '0;
    if (stb.rdStatus)      rdNibble = devReq[int'(stb.rdLevel)*DEVS +: DEVS];
    else if (stb.rdEnable) rdNibble = enMask[int'(stb.rdLevel)*DEVS +: DEVS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= {{(DATA_W-DEVS){1'b0}}, rdNibble};
  end

endmodule

// File: rtl/irq_level_agg.sv
module irq_level_agg
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [15:0]       devReq,
  output logic [3:0]        irqLevel
);

  strobe_t           stb;
  logic [REQ_W-1:0]  enMask;

  irq_agg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busWdata (busWdata),
    .stb      (stb)
  );

  irq_agg_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .devReq   (devReq),
    .enMask   (enMask),
    .irqLevel (irqLevel),
    .busRdata (busRdata)
  );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic [15:0]       devReq,
  input logic [REQ_W-1:0]  enMask,
  input logic [3:0]        irqLevel
);

  logic hit;
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < LEVELS; i++) begin
      if (busAddr == ADDR_W'(statusOffset(i)) || busAddr == ADDR_W'(enableOffset(i)))
        hit = 1'b1;
    end
  end

  // R8: undecoded offsets read as zero
  a_r8_undecoded_zero: assert property (@(posedge clk) disable iff (!rstN)
    !hit |=> busRdata == 8'h00);

  for (genvar g = 0; g < LEVELS; g++) begin : gChk
    localparam logic [ADDR_W-1:0] STA = ADDR_W'(statusOffset(g));
    localparam logic [ADDR_W-1:0] ENA = ADDR_W'(enableOffset(g));

    // R1: status readback one cycle later
    a_r1_status_read: assert property (@(posedge clk) disable iff (!rstN)
      busAddr == STA |=> busRdata == {4'b0, $past(devReq[g*DEVS +: DEVS])});

    // R2: enable readback one cycle later
    a_r2_enable_read: assert property (@(posedge clk) disable iff (!rstN)
      busAddr == ENA |=> busRdata == {4'b0, $past(enMask[g*DEVS +: DEVS])});

    // R3: set mode ORs in the named bits
    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == ENA && busWdata[7]) |=>
        enMask[g*DEVS +: DEVS] == ($past(enMask[g*DEVS +: DEVS]) | $past(busWdata[3:0])));

    // R4: clear mode removes the named bits
    a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == ENA && !busWdata[7]) |=>
        enMask[g*DEVS +: DEVS] == ($past(enMask[g*DEVS +: DEVS]) & ~$past(busWdata[3:0])));

    // R8 / R9: enable bits move only on a write to their own register
    a_r9_enable_hold: assert property (@(posedge clk) disable iff (!rstN)
      !(busWr && busAddr == ENA) |=> $stable(enMask[g*DEVS +: DEVS]));

    // R5: no request or no enable means no level output
    a_r5_quiet_no_req: assert property (@(posedge clk) disable iff (!rstN)
      devReq[g*DEVS +: DEVS] == '0 |-> !irqLevel[g]);
    a_r5_quiet_no_en: assert property (@(posedge clk) disable iff (!rstN)
      enMask[g*DEVS +: DEVS] == '0 |-> !irqLevel[g]);
  end

endmodule

bind irq_level_agg irq_agg_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/irq_level_agg_tb_top.sv
`timescale 1ns/1ps
module irq_level_agg_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [15:0] devReq = '0;
  logic [3:0]  irqLevel;

  int checks = 0;
  int fails  = 0;
  logic [3:0] expEn [4];

  always #2.5 clk = ~clk;

  irq_level_agg #(.ADDR_W(12)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .devReq(devReq), .irqLevel(irqLevel)
  );

  function automatic logic [11:0] stAddr(int l); return 12'(32'h130 + 16*l); endfunction
  function automatic logic [11:0] enAddr(int l); return 12'(32'h134 + 16*l); endfunction

  function automatic logic isReg(logic [11:0] a);
    for (int l = 0; l < 4; l++) if (a == stAddr(l) || a == enAddr(l)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [3:0] expIrq();
    logic [3:0] r;
    for (int l = 0; l < 4; l++) r[l] = |(devReq[4*l +: 4] & expEn[l]);
    return r;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWr = 1'b1; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
    for (int l = 0; l < 4; l++)
      if (a == enAddr(l))
        expEn[l] = d[7] ? (expEn[l] | d[3:0]) : (expEn[l] & ~d[3:0]);
  endtask

  task automatic rdReg(logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    @(negedge clk);
    d = busRdata;
  endtask

  task automatic checkAllEnables(string tag);
    logic [7:0] v;
    for (int l = 0; l < 4; l++) begin
      rdReg(enAddr(l), v);
      check(tag, v, {4'b0, expEn[l]});
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stimulus
    logic [7:0] v;
    for (int l = 0; l < 4; l++) expEn[l] = '0;
    repeat (3) @(negedge clk);
    check("R7 rdata after reset", busRdata, 8'h00);
    check("R7 irq after reset", {4'b0, irqLevel}, 8'h00);
    rstN = 1'b1;

    // R7: enables start cleared even with every device requesting
    devReq = 16'hFFFF;
    #1;
    check("R7 irq low with all requests", {4'b0, irqLevel}, 8'h00);
    checkAllEnables("R7 enable reset value");
    for (int l = 0; l < 4; l++) begin
      rdReg(stAddr(l), v);
      check("R1 status all requesting", v, 8'h0F);
    end

    // R3 / R4: set, set, clear sequence on level 4 (index 1)
    wrReg(enAddr(1), 8'h81);
    rdReg(enAddr(1), v); check("R3 set device 0", v, 8'h01);
    wrReg(enAddr(1), 8'h86);
    rdReg(enAddr(1), v); check("R3 set devices 1,2", v, 8'h07);
    wrReg(enAddr(1), 8'h02);
    rdReg(enAddr(1), v); check("R4 clear device 1", v, 8'h05);
    // R4: bits [6:4] carry no meaning
    wrReg(enAddr(1), 8'hF0);
    rdReg(enAddr(1), v); check("R4 upper bits in set mode", v, 8'h05);
    wrReg(enAddr(1), 8'h70);
    rdReg(enAddr(1), v); check("R4 upper bits in clear mode", v, 8'h05);
    checkAllEnables("R9 other levels untouched");

    // R5 / R6 / R1 / R2: every enable mask against every request pattern
    for (int l = 0; l < 4; l++) begin
      for (int e = 0; e < 16; e++) begin
        wrReg(enAddr(l), 8'h0F);
        wrReg(enAddr(l), 8'h80 | 8'(e));
        check("R5 irq after enable write", {4'b0, irqLevel}, {4'b0, expIrq()});
        rdReg(enAddr(l), v);
        check("R2 R6 enable readback", v, {4'b0, 4'(e)});
        for (int r = 0; r < 16; r++) begin
          @(negedge clk);
          devReq = {4{~4'(r)}};
          devReq[4*l +: 4] = 4'(r);
          #1;
          check("R5 R6 level output", {4'b0, irqLevel}, {4'b0, expIrq()});
          rdReg(stAddr(l), v);
          check("R1 R6 status readback", v, {4'b0, 4'(r)});
        end
      end
      checkAllEnables("R9 enables after level sweep");
    end

    // R8: undecoded offsets read zero and ignore writes
    devReq = 16'hA5C3;
    for (int a = 0; a < 'h200; a++) begin
      if (!isReg(12'(a))) begin
        wrReg(12'(a), 8'h8F);
        rdReg(12'(a), v);
        check("R8 undecoded read", v, 8'h00);
      end
    end
    wrReg(12'hFFF, 8'h0F);
    rdReg(12'hFFF, v); check("R8 high undecoded read", v, 8'h00);
    checkAllEnables("R8 enables after undecoded writes");

    // R8: writes to status registers are ignored
    for (int l = 0; l < 4; l++) begin
      wrReg(stAddr(l), 8'h8F);
      wrReg(stAddr(l), 8'h0F);
      rdReg(stAddr(l), v);
      check("R8 status after write", v, {4'b0, devReq[4*l +: 4]});
    end
    checkAllEnables("R8 enables after status writes");
    #1;
    check("R5 final level output", {4'b0, irqLevel}, {4'b0, expIrq()});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule